// File: doc/BRIEF.md
# Ten-Bit Serializer with Wrap Loopback

This block is the transmit half of a ten-bit serial link. It takes words that are already line-coded, ten bits each, and sends them out one bit per bit clock, least significant bit first. The words follow one another with no idle bits between them.

One bit-rate clock drives the whole block. An internal divide-by-ten timer takes the place of a frequency-multiplying PLL. Once in every ten clocks the timer raises `word_take`. The host must present the next word on `tx_word` during that cycle, and the block captures it on the rising edge that ends the cycle.

A wrap control picks where the serial stream goes. With wrap low, the stream drives the external line output. With wrap high, the stream goes to an internal loopback output that feeds the receiver, and the line output is parked at logic 1.

A small controller sequences start-up. It has three states:
- `ST_IDLE`: the state after reset. The stream is held at 1.
- `ST_PRIME`: a first word sits in the input register. The stream is still held at 1.
- `ST_STREAM`: shift-register bits are driven onto the stream.

Its transitions are:
- `IDLE->PRIME` on the first capture edge.
- `PRIME->STREAM` on the following reload edge.
- `STREAM->STREAM` from then on.
- Any state returns to `ST_IDLE` on reset.

Top module: `ser10_wrap_tx`

## Requirements
- R1: Reset is synchronous and active high. On every clock edge where `rst` is sampled high, the block goes to its idle state. In the period after such an edge, `line_out` = 1, `loop_out` = 1 and `word_take` = 0, whatever `wrap_en` is.
- R2: `word_take` is high for exactly one clock period in every ten. After reset is released, it is first high in the period following the 9th rising edge that samples `rst` low. `tx_word` is captured on the rising edge that ends each such period.
- R3: Values on `tx_word` at rising edges where `word_take` is low have no effect on the serial stream.
- R4: Let a word be captured at edge N. Its bit i, counting from bit 0 (the LSB, sent first) up to bit 9, is the stream value during the period that follows edge N+1+i. Bit 0 of the next word therefore follows bit 9 directly, with no gap.
- R5: After reset, the stream stays 1 until the first captured word starts. That is 10 idle periods after release, whatever `tx_word` carries.
- R6: While `wrap_en` = 1, `line_out` = 1 and `loop_out` equals the stream bit.
- R7: While `wrap_en` = 0, `line_out` equals the stream bit and `loop_out` = 1.
- R8: `wrap_en` changes route the stream in the same period they are applied, including in `word_take` periods. They never delay, drop or reorder stream bits.
- R9: A reset applied in the middle of a stream discards the words in flight. The block then behaves as in R1, R2 and R5 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_word | input | 10 | Pre-coded parallel word, bit 0 sent first |
| wrap_en | input | 1 | 1 = route stream to loopback, park line high |
| word_take | output | 1 | High in the cycle whose ending edge captures `tx_word` |
| line_out | output | 1 | External serial output |
| loop_out | output | 1 | Internal loopback serial output toward the receiver |

## Verification
A wrap switch can fall in the same cycle as a word capture and a shift-register reload. In that case the routing change and the word hand-over happen together. The bench provokes this by flipping `wrap_en` exactly in the `word_take` cycles while it presents a new word, and separately by toggling `wrap_en` every cycle. In every cycle it predicts both outputs from the R4 bit schedule and the R6/R7 routing. Any lost, repeated or shifted bit therefore shows up as a mismatch on one of the two outputs.

// File: rtl/ser10_pkg.sv
package ser10_pkg;

    // Start-up sequencing of the serial stream
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2
    } ser_state_e;

endpackage

// File: rtl/ser10_byte_timer.sv
module ser10_byte_timer #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst,
    output logic strobe,
    output logic load
);
    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // capture edge ends the last count, reload edge ends the first one
    assign strobe = (cnt == LAST);
    assign load   = (cnt == '0);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe); // R2
    AST_LOAD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> load); // R4

endmodule

// File: rtl/ser10_shifter.sv
module ser10_shifter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         sbit
);
    logic [W-1:0] in_reg;
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_reg <= '1;
            sreg   <= '1;
        end else begin
            if (capture) begin
                in_reg <= din;
            end
            if (load) begin
                sreg <= in_reg;
            end else begin
                sreg <= {1'b1, sreg[W-1:1]};
            end
        end
    end

    assign sbit = sreg[0];

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(in_reg)); // R3

endmodule

// File: rtl/ser10_ctrl.sv
module ser10_ctrl
    import ser10_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic load,
    input  logic sbit,
    output logic stream_bit
);
    ser_state_e state;
    ser_state_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (strobe) state_nx = ST_PRIME;
            ST_PRIME:  if (load)   state_nx = ST_STREAM;
            ST_STREAM: state_nx = ST_STREAM;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        stream_bit = 1'b1;
        unique case (state)
            ST_IDLE:   stream_bit = 1'b1;
            ST_PRIME:  stream_bit = 1'b1;
            ST_STREAM: stream_bit = sbit;
            default:   stream_bit = 1'b1;
        endcase
    end

    AST_PRIME_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && strobe) |=> (state == ST_PRIME)); // R5
    AST_STREAM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STREAM) |=> (state == ST_STREAM)); // R8

endmodule

// File: rtl/ser10_wrap_route.sv
module ser10_wrap_route (
    input  logic wrap,
    input  logic stream_bit,
    output logic line,
    output logic loop
);
    always_comb begin
        if (wrap) begin
            line = 1'b1;
            loop = stream_bit;
        end else begin
            line = stream_bit;
            loop = 1'b1;
        end
    end
endmodule

// File: rtl/ser10_wrap_tx.sv
module ser10_wrap_tx #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tx_word,
    input  logic         wrap_en,
    output logic         word_take,
    output logic         line_out,
    output logic         loop_out
);
    logic strobe;
    logic load;
    logic sbit;
    logic stream_bit;

    ser10_byte_timer #(.W(W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .load   (load)
    );

    ser10_shifter #(.W(W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .capture (strobe),
        .load    (load),
        .din     (tx_word),
        .sbit    (sbit)
    );

    ser10_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .load       (load),
        .sbit       (sbit),
        .stream_bit (stream_bit)
    );

    ser10_wrap_route u_route (
        .wrap       (wrap_en),
        .stream_bit (stream_bit),
        .line       (line_out),
        .loop       (loop_out)
    );

    assign word_take = strobe;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (line_out && loop_out && !word_take)); // R1
    AST_LINE_PARKED: assert property (@(posedge clk) disable iff (rst)
        wrap_en |-> line_out); // R6
    AST_LOOP_PARKED: assert property (@(posedge clk) disable iff (rst)
        !wrap_en |-> loop_out); // R7

endmodule

// File: tb/ser10_wrap_tx_tb.sv
`timescale 1ns/1ps
module ser10_wrap_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] tx_word = '0;
    logic       wrap_en = 1'b0;
    logic       word_take;
    logic       line_out;
    logic       loop_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ser10_wrap_tx u_dut (
        .clk       (clk),
        .rst       (rst),
        .tx_word   (tx_word),
        .wrap_en   (wrap_en),
        .word_take (word_take),
        .line_out  (line_out),
        .loop_out  (loop_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Apply reset for one edge and check the outputs it leaves (R1 / R9)
    task automatic t_reset_state(input string req);
        @(negedge clk);
        rst     = 1'b1;
        tx_word = 10'($urandom);
        wrap_en = 1'b0;
        @(negedge clk);
        #1;
        chk(req, "line_out in reset", int'(line_out), 1);
        chk(req, "loop_out in reset", int'(loop_out), 1);
        chk(req, "word_take in reset", int'(word_take), 0);
        wrap_en = 1'b1;
        #1;
        chk(req, "loop_out in reset, wrap on", int'(loop_out), 1);
        chk(req, "line_out in reset, wrap on", int'(line_out), 1);
    endtask

    // Release reset: stream idle for ten periods, first word_take after edge 9 (R2, R5)
    task automatic t_idle(input string req);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            tx_word = 10'($urandom);
            wrap_en = 1'($urandom);
            #1;
            chk(req, "idle line_out", int'(line_out), 1);
            chk(req, "idle loop_out", int'(loop_out), 1);
            chk("R2", "word_take phase after release", int'(word_take), (k == 9) ? 1 : 0);
        end
    endtask

    // Stream four words; mode 0 wrap off, 1 wrap on, 2 toggle every cycle,
    // 3 flip in word_take cycles only
    task automatic t_stream(input logic [9:0] w [4], input int mode, input string req);
        int guard = 0;
        @(negedge clk);
        while (!word_take && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        for (int t = 0; t <= 41; t++) begin
            logic s;
            int   j;
            int   i;
            if (t > 0) @(negedge clk);
            case (mode)
                0: wrap_en = 1'b0;
                1: wrap_en = 1'b1;
                2: wrap_en = t[0];
                default: wrap_en = (((t / 10) % 2) == 1);
            endcase
            if ((t % 10) == 0 && (t / 10) < 4) tx_word = w[t / 10];
            else tx_word = 10'($urandom);
            #1;
            chk("R2", "word_take cadence", int'(word_take), ((t % 10) == 0) ? 1 : 0);
            if (t >= 2) begin
                j = (t - 2) / 10;
                i = (t - 2) % 10;
                s = w[j][i];
                chk(req, "line_out bit", int'(line_out), wrap_en ? 1 : int'(s));
                chk(req, "loop_out bit", int'(loop_out), wrap_en ? int'(s) : 1);
            end
        end
    endtask

    initial begin
        logic [9:0] wa [4];
        logic [9:0] wb [4];
        wa[0] = 10'h17C; wa[1] = 10'h283; wa[2] = 10'h0F5; wa[3] = 10'h30A;
        wb[0] = 10'h3FF; wb[1] = 10'h000; wb[2] = 10'h2AA; wb[3] = 10'h155;

        t_reset_state("R1");
        t_idle("R5");
        t_stream(wa, 0, "R3/R4/R7");
        t_stream(wb, 1, "R4/R6");
        t_stream(wa, 2, "R8");
        t_stream(wb, 3, "R8");
        t_reset_state("R9");
        t_idle("R9");
        t_stream(wb, 0, "R9/R4");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule